// File: doc/BRIEF.md
# Delay-Stepped Integer Clock Divider

This block divides a fast input clock by an integer N of 2 or more and places the phase of the divided output in whole input-clock cycles. Phase is set in two ways. A coarse start offset is captured when a restart pulse arrives: the output is forced low, the divide value and fixed offset are latched, and the first rising edge appears after a countdown. A fine adjustment is then made while the output keeps toggling: each requested step stretches one low phase by a single input cycle, so the output is retarded without any short pulse.

For divide values below 8 the start point carries an extra shift that depends on N. A system that wants every output edge at a target delay D sets the fixed offset F (usually 15), restarts, and then requests (D - F - shift) mod N steps. A busy flag stays high while steps remain, and no new step request is taken until it clears.

Top module: `dlydiv`

## Requirements
- R1: While reset is high and in the first cycle after it, `div_out` and `busy` are 0.
- R2: `div_sel` and `fix_dly` are sampled only at a clock edge where `sync_req` is 1; changing them at other times leaves the output period and phase unchanged.
- R3: From the edge that samples `sync_req` the output is low, and its first rising edge follows the clock edge F + S + 2 edges later, where F is the latched fixed offset and S is the start shift of R4.
- R4: The start shift S for the latched divide value N is +1 for N=2, +1 for N=3, 0 for N=4, +3 for N=5, -1 for N=6, 0 for N=7 and 0 for any N of 8 or more.
- R5: Without steps, rising edges recur every N input cycles and each high phase lasts floor(N/2) cycles, so even N gives 50% duty and odd N a high phase one cycle shorter than the low phase.
- R6: A `div_sel` value of 0 or 1 is latched as N=2.
- R7: A step request (`step_go` and `step_en` both 1 at an edge while `busy` is 0 and the output is running) loads `step_cnt`; `busy` is 1 after that edge exactly when the count is nonzero.
- R8: Each pending step lengthens one low phase by one cycle, at most one per output period, so every rise-to-rise interval is N or N+1, high phases keep their length, and exactly `step_cnt` intervals are N+1.
- R9: A step request made while `busy` is 1, or with `step_en` at 0, is ignored.
- R10: After s steps, rising edges sit at F + S + 2 + s cycles (mod N) after the restart edge; requesting s = (D - F - S) mod N puts them at D + 2 (mod N).
- R11: A restart while steps are pending discards them: after that edge `busy` and `div_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock; one delay unit is one of its periods |
| rst | input | 1 | Synchronous reset, active high |
| sync_req | input | 1 | Restart pulse: latches divide value and fixed offset, forces output low |
| div_sel | input | DIV_W | Divide value N (values below 2 act as 2) |
| fix_dly | input | DLY_W | Fixed start offset F in input cycles |
| step_en | input | 1 | Enables step requests |
| step_cnt | input | STEP_W | Number of one-cycle retard steps to apply |
| step_go | input | 1 | Step request trigger |
| div_out | output | 1 | Divided clock output |
| busy | output | 1 | High while requested steps remain |

## Verification
Every divide value from 2 to 9 is restarted with the fixed offset at 15 and a random target delay, which separates the per-value start shifts of the table from a flat offset and shows the step formula landing edges on the target phase. Random divide values and offsets add cases where the shift and offset interact differently, while zero and one as divide values probe the clamp. Step requests are tried with a count of zero, with the enable low, and repeated while busy, which distinguishes accepted, disabled and ignored triggers through the count of stretched periods. A restart issued mid-stepping shows pending steps being dropped.

// File: rtl/dlydiv_pkg.sv
package dlydiv_pkg;

  // Extra start offset, in input cycles, for small divide values.
  function automatic int start_shift(input int n);
    case (n)
      2, 3:    return 1;
      5:       return 3;
      6:       return -1;
      default: return 0;
    endcase
  endfunction

  // Number of input cycles the output stays high in one period.
  function automatic int high_len(input int n);
    return n / 2;
  endfunction

endpackage

// File: rtl/dlydiv_start.sv
module dlydiv_start
  import dlydiv_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_req,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [DLY_W-1:0] fix_dly,
  output logic             run,
  output logic             start_ev,
  output logic [DIV_W-1:0] cur_div
);
  localparam int HOLD_W = DLY_W + 2;

  logic [HOLD_W-1:0] hold_q;
  logic              arm_q;
  logic [DIV_W-1:0]  eff_div;
  logic [HOLD_W-1:0] hold_load;

  assign eff_div   = (div_sel < DIV_W'(2)) ? DIV_W'(2) : div_sel;
  assign hold_load = HOLD_W'(int'(fix_dly) + start_shift(int'(eff_div)) + 1);
  assign start_ev  = arm_q && (hold_q == '0) && !sync_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      arm_q   <= 1'b0;
      run     <= 1'b0;
      cur_div <= DIV_W'(2);
    end else if (sync_req) begin
      hold_q  <= hold_load;
      arm_q   <= 1'b1;
      run     <= 1'b0;
      cur_div <= eff_div;
    end else if (arm_q) begin
      if (hold_q == '0) begin
        arm_q <= 1'b0;
        run   <= 1'b1;
      end else begin
        hold_q <= hold_q - HOLD_W'(1);
      end
    end
  end
endmodule

// File: rtl/dlydiv_phase.sv
module dlydiv_phase #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_req,
  input  logic             run,
  input  logic             start_ev,
  input  logic             stretch_ev,
  input  logic [DIV_W-1:0] cur_div,
  output logic             div_out,
  output logic             at_last,
  output logic             wrap_ev
);
  logic [DIV_W-1:0] p_q;
  logic [DIV_W-1:0] p_nxt;
  logic [DIV_W-1:0] hi_cnt;

  assign hi_cnt  = cur_div >> 1;
  assign at_last = run && (p_q == cur_div - DIV_W'(1));
  assign wrap_ev = at_last && !stretch_ev && !sync_req;
  assign p_nxt   = p_q + DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst || sync_req) begin
      p_q     <= '0;
      div_out <= 1'b0;
    end else if (start_ev) begin
      p_q     <= '0;
      div_out <= 1'b1;
    end else if (run) begin
      if (stretch_ev) begin
        div_out <= 1'b0;
      end else if (at_last) begin
        p_q     <= '0;
        div_out <= 1'b1;
      end else begin
        p_q     <= p_nxt;
        div_out <= (p_nxt < hi_cnt);
      end
    end
  end
endmodule

// File: rtl/dlydiv_step.sv
module dlydiv_step #(
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_req,
  input  logic              run,
  input  logic              at_last,
  input  logic              step_en,
  input  logic              step_go,
  input  logic [STEP_W-1:0] step_cnt,
  output logic              busy,
  output logic              stretch_ev,
  output logic              accept_ev
);
  logic [STEP_W-1:0] left_q;
  logic              str_q;

  assign busy       = (left_q != '0);
  assign stretch_ev = at_last && busy && !str_q && !sync_req;
  assign accept_ev  = step_go && step_en && !busy && run && !sync_req;

  always_ff @(posedge clk) begin
    if (rst || sync_req) begin
      left_q <= '0;
      str_q  <= 1'b0;
    end else begin
      str_q <= stretch_ev;
      if (accept_ev)       left_q <= step_cnt;
      else if (stretch_ev) left_q <= left_q - STEP_W'(1);
    end
  end
endmodule

// File: rtl/dlydiv.sv
module dlydiv #(
  parameter int DIV_W  = 6,
  parameter int DLY_W  = 4,
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_req,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [DLY_W-1:0]  fix_dly,
  input  logic              step_en,
  input  logic [STEP_W-1:0] step_cnt,
  input  logic              step_go,
  output logic              div_out,
  output logic              busy
);
  logic             run_w;
  logic             start_ev;
  logic [DIV_W-1:0] cur_div;
  logic             at_last;
  logic             wrap_ev;
  logic             stretch_ev;
  logic             accept_ev;

  dlydiv_start #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_start (
    .clk(clk), .rst(rst), .sync_req(sync_req), .div_sel(div_sel),
    .fix_dly(fix_dly), .run(run_w), .start_ev(start_ev), .cur_div(cur_div)
  );

  dlydiv_phase #(.DIV_W(DIV_W)) u_phase (
    .clk(clk), .rst(rst), .sync_req(sync_req), .run(run_w),
    .start_ev(start_ev), .stretch_ev(stretch_ev), .cur_div(cur_div),
    .div_out(div_out), .at_last(at_last), .wrap_ev(wrap_ev)
  );

  dlydiv_step #(.STEP_W(STEP_W)) u_step (
    .clk(clk), .rst(rst), .sync_req(sync_req), .run(run_w),
    .at_last(at_last), .step_en(step_en), .step_go(step_go),
    .step_cnt(step_cnt), .busy(busy), .stretch_ev(stretch_ev),
    .accept_ev(accept_ev)
  );
endmodule

// File: rtl/dlydiv_chk.sv
module dlydiv_chk (
  input logic clk,
  input logic rst,
  input logic sync_req,
  input logic div_out,
  input logic busy,
  input logic run,
  input logic start_ev,
  input logic wrap_ev,
  input logic stretch_ev,
  input logic accept_ev
);
  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !div_out);

  // R11
  sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sync_req |=> (!div_out && !busy));

  // R8
  stretch_low_chk: assert property (@(posedge clk) disable iff (rst)
    stretch_ev |=> !div_out);

  // R9
  busy_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !sync_req && !stretch_ev) |=> busy);

  // R7
  busy_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(accept_ev));

  // R5
  rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div_out) |-> $past(start_ev || wrap_ev));
endmodule

bind dlydiv dlydiv_chk u_chk (
  .clk(clk), .rst(rst), .sync_req(sync_req), .div_out(div_out),
  .busy(busy), .run(run_w), .start_ev(start_ev), .wrap_ev(wrap_ev),
  .stretch_ev(stretch_ev), .accept_ev(accept_ev)
);

// File: tb/dlydiv_test.sv
module dlydiv_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_req = 1'b0;
  logic [5:0] div_sel = 6'd2;
  logic [3:0] fix_dly = 4'd0;
  logic       step_en = 1'b0;
  logic [5:0] step_cnt = 6'd0;
  logic       step_go = 1'b0;
  logic       div_out;
  logic       busy;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic prev_o = 1'b0;
  int rq[$];
  int fq[$];

  dlydiv uut (
    .clk(clk), .rst(rst), .sync_req(sync_req), .div_sel(div_sel),
    .fix_dly(fix_dly), .step_en(step_en), .step_cnt(step_cnt),
    .step_go(step_go), .div_out(div_out), .busy(busy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (div_out && !prev_o) rq.push_back(cyc);
    if (!div_out && prev_o) fq.push_back(cyc);
    prev_o = div_out;
  end

  function automatic int b_shift(input int n);
    if (n == 2 || n == 3) return 1;
    if (n == 5) return 3;
    if (n == 6) return -1;
    return 0;
  endfunction

  function automatic int b_mod(input int a, input int n);
    return ((a % n) + n) % n;
  endfunction

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic get_rise(output int t);
    t = -1;
    for (int k = 0; k < 400 && rq.size() == 0; k++) @(negedge clk);
    if (rq.size() > 0) t = rq.pop_front();
  endtask

  task automatic get_fall(output int t);
    t = -1;
    for (int k = 0; k < 400 && fq.size() == 0; k++) @(negedge clk);
    if (fq.size() > 0) t = fq.pop_front();
  endtask

  // Restart at a negedge; returns the number of the sampling edge.
  task automatic restart(input int n, input int f, output int se);
    div_sel  = 6'(n);
    fix_dly  = 4'(f);
    sync_req = 1'b1;
    se = cyc + 1;
    @(negedge clk);
    sync_req = 1'b0;
    chk(!busy && !div_out, "R11 clear after restart", int'(busy), 0);
    @(negedge clk);
    rq.delete();
    fq.delete();
  endtask

  task automatic run_case(input int n, input int f, input int desired,
                          input bit try_dis, input bit try_busy);
    int ne, sh, se, t1, f1, t2, r, rn, s, longs;
    ne = (n < 2) ? 2 : n;
    sh = b_shift(ne);
    restart(n, f, se);
    // R2: inputs moved away without a restart must not matter
    div_sel = 6'(ne + 3);
    fix_dly = 4'(f ^ 5);
    get_rise(t1);
    chk(t1 == se + f + sh + 2, "R3/R4 first rise", t1 - se, f + sh + 2);
    get_fall(f1);
    chk(f1 - t1 == ne / 2, "R5 high width", f1 - t1, ne / 2);
    get_rise(t2);
    chk(t2 - t1 == ne, (n < 2) ? "R6 clamped period" : "R2/R5 period", t2 - t1, ne);
    r = t2;
    if (try_dis) begin
      step_en = 1'b0; step_cnt = 6'd1; step_go = 1'b1;
      @(negedge clk);
      step_go = 1'b0;
      chk(!busy, "R9 disabled request", int'(busy), 0);
      get_rise(rn);
      chk(rn - r == ne, "R9 disabled period", rn - r, ne);
      r = rn;
    end
    s = b_mod(desired - f - sh, ne);
    step_en = 1'b1; step_cnt = 6'(s); step_go = 1'b1;
    @(negedge clk);
    step_go = 1'b0;
    chk(busy == (s != 0), "R7 busy after request", int'(busy), int'(s != 0));
    if (try_busy && busy) begin
      step_cnt = 6'(s + 1); step_go = 1'b1;
      @(negedge clk);
      step_go = 1'b0;
    end
    longs = 0;
    for (int i = 0; i < s + 2; i++) begin
      get_rise(rn);
      chk(rn - r == ne || rn - r == ne + 1, "R8 interval", rn - r, ne);
      if (rn - r == ne + 1) longs++;
      r = rn;
    end
    chk(longs == s, try_busy ? "R9 stretched periods" : "R8 stretched periods", longs, s);
    chk(!busy, "R7 busy cleared", int'(busy), 0);
    chk(b_mod(r - se - 2 - desired, ne) == 0, "R10 final phase",
        b_mod(r - se - 2, ne), b_mod(desired, ne));
    step_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R1..: got %0d cycles expected fewer", 150000);
    report();
    $finish;
  end

  initial begin
    int se, t;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(!div_out && !busy, "R1 during reset", int'(div_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!div_out && !busy, "R1 after reset", int'(busy), 0);

    // Directed: every divide value 2..9 with fixed offset 15
    for (int n = 2; n <= 9; n++)
      run_case(n, 15, int'($urandom_range(0, 30)), n == 3, n == 7 || n == 9);

    // Clamp of small divide values
    run_case(0, 4, 5, 1'b0, 1'b0);
    run_case(1, 7, 2, 1'b0, 1'b0);

    // Random mix
    for (int i = 0; i < 16; i++)
      run_case(int'($urandom_range(2, 12)), int'($urandom_range(1, 15)),
               int'($urandom_range(0, 40)), i[0], i[1]);

    // R11: restart with steps pending
    restart(8, 3, se);
    get_rise(t);
    step_en = 1'b1; step_cnt = 6'd5; step_go = 1'b1;
    @(negedge clk);
    step_go = 1'b0;
    chk(busy, "R11 busy before restart", int'(busy), 1);
    restart(8, 3, se);
    chk(!busy, "R11 steps dropped", int'(busy), 0);
    get_rise(t);
    chk(t == se + 5, "R11 first rise after restart", t - se, 5);

    report();
    $finish;
  end
endmodule